// File: doc/BRIEF.md
# Cascadable 32-bit Timer Pair with Posted Register Writes

This block holds two 32-bit up-counting timers, a low timer and a high timer. They share one register port and one timer-domain count enable (`tmr_tick`). A one-bit chaining select decides what drives the high timer. When the select is clear, the high timer counts `tmr_tick` like the low timer. When it is set, the only event that advances the high timer is an overflow of the low timer. The low timer then acts as a 32-bit prescaler, and the pair behaves as one 64-bit timer.

Each timer has four registers: a control register (run and auto-reload bits), a load value, a counter, and a reload trigger. Software writes to these four registers are posted. The write is captured in one bus cycle. It then crosses into the timer domain through a three-stage pipeline that moves only on that timer's own count enable. While a write is in flight, its bit in the timer's pending-status register reads 1.

A second write to a register whose earlier write is still pending is held off with `bus_wait`. Counter reads come back through a matching three-stage shadow, so the value read lags the live count. Each timer raises a one-cycle overflow interrupt in the cycle its counter wraps from all ones.

Top module: `casc_timer_pair`

## Requirements
- R1: After reset every register reads 0, `bus_wait` is 0 and both overflow interrupts are 0.
- R2: Address map, with `bus_addr[3]` selecting the timer (0 low, 1 high) and `bus_addr[2:0]` selecting the register: 0 control, 1 load, 2 counter, 3 trigger (reads 0), 4 pending status, 5 chaining select (bit 0; low timer address only; reads 0 at address 0xD). Control and load read back their committed values.
- R3: A write to control, load, counter or trigger takes effect on the third timer enable after the clock edge that captures it. Enables are `tmr_tick`, or low-timer overflows for the high timer when chained. Until then, pending-status bit 0 (control), bit 1 (load), bit 2 (counter) or bit 3 (trigger) reads 1. The bit reads 0 from the commit edge on.
- R4: Cycles without a timer enable do not advance a posted write, so its pending bit stays 1.
- R5: A write to a register whose pending bit is 1 is held with `bus_wait` = 1 and is not captured. It is captured once the bit clears, and then completes normally.
- R6: With control bit 0 (run) set, the counter advances by one on each timer enable. When the count is 0xFFFFFFFF and an enable arrives, that timer's overflow interrupt is 1 for that single cycle.
- R7: On overflow, the counter loads the load value if control bit 1 (auto-reload) is set, and 0 otherwise. A load of 0xFFFFFFFA gives one overflow every 6 enables.
- R8: A write of any data to the trigger register reloads the counter from the load register when it commits.
- R9: A counter read returns the count sampled three timer enables earlier.
- R10: With the chaining select set, each low-timer overflow advances the high timer by exactly one, and a high-timer overflow occurs only together with a low-timer overflow.
- R11: With the chaining select clear, the high timer counts on `tmr_tick` on its own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the bus port and the timer domain |
| rst_n | input | 1 | Asynchronous active-low reset |
| tmr_tick | input | 1 | Timer-domain count enable, one cycle per timer clock |
| bus_wr | input | 1 | Register write request |
| bus_addr | input | 4 | Timer select (bit 3) and register select (bits 2:0) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| bus_wait | output | 1 | Write held off: the target register's earlier write is still pending |
| irq_ovf_lo | output | 1 | One-cycle overflow pulse of the low timer |
| irq_ovf_hi | output | 1 | One-cycle overflow pulse of the high timer |

## Verification
With an enable in every cycle, a write captured at edge E0 commits at E3, so its pending bit and committed value are sampled after E2 (old) and after E3 (new). A counter written at E0 reads back its old value after E5 and its new value after E6, which is three further enables for the read shadow. The sparse-enable case counts enable pulses instead of cycles, and the chained case counts low-timer overflows: a high control write commits on the third low overflow, and the first high overflow then coincides with the ninth low overflow when the high load value is 0xFFFFFFFA. Every sample is taken at a falling edge, one step after the rising edge it depends on.

// File: rtl/ctp_pkg.sv
package ctp_pkg;
  localparam int ADDR_W = 4;
  localparam int NPOST  = 4;   // posted registers per timer
  localparam int NTMR   = 2;
  // register select codes, bus_addr[2:0]
  localparam logic [2:0] A_CTRL  = 3'd0;
  localparam logic [2:0] A_LOAD  = 3'd1;
  localparam logic [2:0] A_COUNT = 3'd2;
  localparam logic [2:0] A_TRIG  = 3'd3;
  localparam logic [2:0] A_PEND  = 3'd4;
  localparam logic [2:0] A_CASC  = 3'd5;
  // index of each posted register in pending / accept vectors
  localparam int IX_CTRL  = 0;
  localparam int IX_LOAD  = 1;
  localparam int IX_COUNT = 2;
  localparam int IX_TRIG  = 3;
  // control bits
  localparam int CB_RUN  = 0;
  localparam int CB_AUTO = 1;
endpackage

// File: rtl/ctp_post_pipe.sv
module ctp_post_pipe #(
  parameter int SYNC_CLKS = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tmr_en,
  input  logic accept,
  output logic busy,
  output logic commit
);
  logic [SYNC_CLKS-1:0] tok_q, tok_d;

  always_comb begin
    tok_d = tok_q;
    if (tmr_en) tok_d = {tok_q[SYNC_CLKS-2:0], 1'b0};
    if (accept) tok_d[0] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tok_q <= '0;
    else        tok_q <= tok_d;
  end

  assign busy   = |tok_q;
  assign commit = tmr_en & tok_q[SYNC_CLKS-1];
endmodule

// File: rtl/ctp_timer_core.sv
module ctp_timer_core
  import ctp_pkg::*;
#(
  parameter int CNT_W     = 32,
  parameter int SYNC_CLKS = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tmr_en,
  input  logic [NPOST-1:0] wr_acc,
  input  logic [CNT_W-1:0] wdata,
  output logic [NPOST-1:0] pend,
  output logic [1:0]       ctrl_o,
  output logic [CNT_W-1:0] load_o,
  output logic [CNT_W-1:0] cnt_view,
  output logic             ovf
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [NPOST-1:0] commit;

  for (genvar i = 0; i < NPOST; i++) begin : g_post
    ctp_post_pipe #(.SYNC_CLKS(SYNC_CLKS)) u_pipe (
      .clk    (clk),
      .rst_n  (rst_n),
      .tmr_en (tmr_en),
      .accept (wr_acc[i]),
      .busy   (pend[i]),
      .commit (commit[i])
    );
  end

  logic [1:0]       ctrl_q, ctrl_d, ctrl_stg_q, ctrl_stg_d;
  logic [CNT_W-1:0] load_q, load_d, load_stg_q, load_stg_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_stg_q, cnt_stg_d;
  logic [SYNC_CLKS-1:0][CNT_W-1:0] view_q, view_d;

  assign ovf = tmr_en & ctrl_q[CB_RUN] & (cnt_q == CNT_MAX);

  always_comb begin
    ctrl_stg_d = wr_acc[IX_CTRL]  ? wdata[1:0] : ctrl_stg_q;
    load_stg_d = wr_acc[IX_LOAD]  ? wdata      : load_stg_q;
    cnt_stg_d  = wr_acc[IX_COUNT] ? wdata      : cnt_stg_q;

    ctrl_d = commit[IX_CTRL] ? ctrl_stg_q : ctrl_q;
    load_d = commit[IX_LOAD] ? load_stg_q : load_q;

    cnt_d = cnt_q;
    if (tmr_en && ctrl_q[CB_RUN]) begin
      if (ovf) cnt_d = ctrl_q[CB_AUTO] ? load_q : '0;
      else     cnt_d = cnt_q + CNT_W'(1);
    end
    if (commit[IX_TRIG])  cnt_d = load_q;
    if (commit[IX_COUNT]) cnt_d = cnt_stg_q;

    view_d = view_q;
    if (tmr_en) view_d = {view_q[SYNC_CLKS-2:0], cnt_q};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q     <= '0;
      ctrl_stg_q <= '0;
      load_q     <= '0;
      load_stg_q <= '0;
      cnt_q      <= '0;
      cnt_stg_q  <= '0;
      view_q     <= '0;
    end else begin
      ctrl_q     <= ctrl_d;
      ctrl_stg_q <= ctrl_stg_d;
      load_q     <= load_d;
      load_stg_q <= load_stg_d;
      cnt_q      <= cnt_d;
      cnt_stg_q  <= cnt_stg_d;
      view_q     <= view_d;
    end
  end

  assign ctrl_o   = ctrl_q;
  assign load_o   = load_q;
  assign cnt_view = view_q[SYNC_CLKS-1];
endmodule

// File: rtl/casc_timer_pair.sv
module casc_timer_pair
  import ctp_pkg::*;
#(
  parameter int CNT_W     = 32,
  parameter int SYNC_CLKS = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tmr_tick,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic              bus_wait,
  output logic              irq_ovf_lo,
  output logic              irq_ovf_hi
);
  logic       tsel;
  logic [2:0] rsel;
  assign tsel = bus_addr[ADDR_W-1];
  assign rsel = bus_addr[2:0];

  logic [NTMR-1:0][NPOST-1:0] acc, pend;
  logic [NTMR-1:0][1:0]       ctrl_v;
  logic [NTMR-1:0][CNT_W-1:0] load_v, view_v;
  logic [NTMR-1:0]            ten, ovf;
  logic                       casc_q, casc_d;

  for (genvar g = 0; g < NTMR; g++) begin : g_tmr
    if (g == 0) begin : g_src
      assign ten[g] = tmr_tick;
    end else begin : g_src
      assign ten[g] = casc_q ? ovf[g-1] : tmr_tick;
    end
    ctp_timer_core #(.CNT_W(CNT_W), .SYNC_CLKS(SYNC_CLKS)) u_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .tmr_en   (ten[g]),
      .wr_acc   (acc[g]),
      .wdata    (bus_wdata),
      .pend     (pend[g]),
      .ctrl_o   (ctrl_v[g]),
      .load_o   (load_v[g]),
      .cnt_view (view_v[g]),
      .ovf      (ovf[g])
    );
  end

  always_comb begin
    for (int t = 0; t < NTMR; t++)
      for (int i = 0; i < NPOST; i++)
        acc[t][i] = bus_wr && (tsel == 1'(t)) && (rsel == 3'(i)) && !pend[t][i];
    bus_wait = bus_wr && (rsel <= A_TRIG) && pend[tsel][rsel[1:0]];
    casc_d   = (bus_wr && !tsel && rsel == A_CASC) ? bus_wdata[0] : casc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) casc_q <= 1'b0;
    else        casc_q <= casc_d;
  end

  always_comb begin
    case (rsel)
      A_CTRL:  bus_rdata = {{(CNT_W-2){1'b0}}, ctrl_v[tsel]};
      A_LOAD:  bus_rdata = load_v[tsel];
      A_COUNT: bus_rdata = view_v[tsel];
      A_PEND:  bus_rdata = {{(CNT_W-NPOST){1'b0}}, pend[tsel]};
      A_CASC:  bus_rdata = {{(CNT_W-1){1'b0}}, casc_q & !tsel};
      default: bus_rdata = '0;
    endcase
  end

  assign irq_ovf_lo = ovf[0];
  assign irq_ovf_hi = ovf[1];
endmodule

// File: rtl/ctp_checker.sv
module ctp_checker #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tmr_tick,
  input logic             irq_lo,
  input logic             irq_hi,
  input logic             casc_on,
  input logic [3:0]       pend_lo,
  input logic [CNT_W-1:0] load_lo
);
  // R10
  casc_hi_with_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (casc_on && irq_hi) |-> irq_lo);
  // R11
  solo_hi_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!casc_on && irq_hi) |-> tmr_tick);
  // R6
  lo_ovf_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_lo |-> tmr_tick);
  // R3
  pend_clear_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pend_lo[1]) |-> $past(tmr_tick));
  // R3
  load_moves_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(tmr_tick) |-> $stable(load_lo));
  // R4
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|pend_lo) && !tmr_tick) |=> (|pend_lo));
endmodule

bind casc_timer_pair ctp_checker #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tmr_tick (tmr_tick),
  .irq_lo   (irq_ovf_lo),
  .irq_hi   (irq_ovf_hi),
  .casc_on  (casc_q),
  .pend_lo  (pend[0]),
  .load_lo  (load_v[0])
);

// File: tb/tb_casc_timer_pair.sv
`timescale 1ns/1ps
module tb_casc_timer_pair;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_wait, irq_lo, irq_hi;

  always #4 clk = ~clk;

  casc_timer_pair dut (
    .clk(clk), .rst_n(rst_n), .tmr_tick(tick), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_wait(bus_wait), .irq_ovf_lo(irq_lo), .irq_ovf_hi(irq_hi)
  );

  int n_chk = 0, n_err = 0;
  int cyc = 0, lo_cnt = 0, hi_cnt = 0, lo_last = 0, lo_prev = 0, hi_at_lo = 0;

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (irq_lo) begin lo_cnt = lo_cnt + 1; lo_prev = lo_last; lo_last = cyc; end
    if (irq_hi) begin hi_cnt = hi_cnt + 1; hi_at_lo = lo_cnt; end
  end

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d, output int waits);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d; waits = 0;
    #1;
    while (bus_wait && waits < 1000) begin @(negedge clk); #1; waits++; end
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    int w;
    bus_write(a, d, w);
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_lo(input int target);
    int k = 0;
    while (lo_cnt < target && k < 2000) begin @(negedge clk); #1; k++; end
  endtask

  task automatic t_reset;
    logic [31:0] v;
    foreach (v[i]) ;
    for (int a = 0; a < 16; a++) begin
      rd(4'(a), v);
      chk(v == 0, "R1 reg after reset", v, 0);
    end
    chk(bus_wait == 0 && irq_lo == 0 && irq_hi == 0, "R1 outputs after reset",
        {bus_wait, irq_lo, irq_hi}, 0);
  endtask

  task automatic t_posted_load;
    logic [31:0] v;
    wr(4'h1, 32'h55);
    rd(4'h4, v); chk(v == 32'h2, "R3 load pending bit1 set", v, 32'h2);
    idle(2);
    rd(4'h1, v); chk(v == 0, "R3 load not yet committed after 2 enables", v, 0);
    rd(4'h4, v); chk(v == 32'h2, "R3 pending still set after 2 enables", v, 32'h2);
    idle(1);
    rd(4'h1, v); chk(v == 32'h55, "R3 R2 load committed on 3rd enable", v, 32'h55);
    rd(4'h4, v); chk(v == 0, "R3 pending cleared", v, 0);
  endtask

  task automatic t_read_lag;
    logic [31:0] v;
    wr(4'h2, 32'h1234_5678);
    idle(5);
    rd(4'h2, v); chk(v == 0, "R9 counter read still old after 5 enables", v, 0);
    idle(1);
    rd(4'h2, v); chk(v == 32'h1234_5678, "R9 counter read new after 6 enables", v, 32'h1234_5678);
  endtask

  task automatic t_trigger;
    logic [31:0] v;
    wr(4'h1, 32'hABCD_0000);
    idle(4);
    wr(4'h3, 32'h0000_DEAD);
    idle(8);
    rd(4'h2, v); chk(v == 32'hABCD_0000, "R8 trigger reloads counter", v, 32'hABCD_0000);
    rd(4'h3, v); chk(v == 0, "R2 trigger reads 0", v, 0);
  endtask

  task automatic t_wait;
    logic [31:0] v;
    int w;
    wr(4'h1, 32'h1111);
    bus_write(4'h1, 32'h2222, w);
    chk(w > 0, "R5 second write held by bus_wait", 32'(w), 1);
    idle(4);
    rd(4'h1, v); chk(v == 32'h2222, "R5 held write completes", v, 32'h2222);
  endtask

  task automatic t_sparse;
    logic [31:0] v;
    tick = 1'b0;
    wr(4'h1, 32'h77);
    idle(3);
    repeat (2) begin tick = 1'b1; @(negedge clk); tick = 1'b0; idle(3); end
    rd(4'h4, v); chk(v == 32'h2, "R4 pending held without 3rd enable", v, 32'h2);
    rd(4'h1, v); chk(v == 32'h2222, "R4 load unchanged without 3rd enable", v, 32'h2222);
    tick = 1'b1; @(negedge clk); tick = 1'b0; #1;
    rd(4'h4, v); chk(v == 0, "R4 pending cleared on 3rd enable", v, 0);
    rd(4'h1, v); chk(v == 32'h77, "R4 load committed on 3rd enable", v, 32'h77);
    tick = 1'b1;
  endtask

  task automatic t_autoreload;
    int base;
    wr(4'h1, 32'hFFFF_FFFA);
    wr(4'h3, 32'h0);
    wr(4'h0, 32'h3);
    base = lo_cnt;
    wait_lo(base + 2);
    chk(lo_last - lo_prev == 6, "R6 R7 overflow period with load FFFFFFFA",
        32'(lo_last - lo_prev), 6);
    @(negedge clk); #1;
    chk(irq_lo == 0, "R6 overflow pulse one cycle wide", 32'(irq_lo), 0);
    wr(4'h0, 32'h0);
    idle(6);
  endtask

  task automatic t_wrap_zero;
    logic [31:0] v;
    int base;
    wr(4'h2, 32'hFFFF_FFFD);
    idle(5);
    base = lo_cnt;
    wr(4'h0, 32'h1);
    idle(40);
    chk(lo_cnt - base == 1, "R7 no reload: single overflow", 32'(lo_cnt - base), 1);
    rd(4'h2, v); chk(v < 64, "R7 no reload: counter wrapped to 0", v, 0);
    wr(4'h0, 32'h0);
    idle(6);
  endtask

  task automatic t_hi_solo;
    int lb, hb;
    wr(4'hA, 32'hFFFF_FFFE);
    idle(5);
    lb = lo_cnt; hb = hi_cnt;
    wr(4'h8, 32'h1);
    idle(20);
    chk(hi_cnt - hb == 1, "R11 high timer overflows on ticks", 32'(hi_cnt - hb), 1);
    chk(lo_cnt == lb, "R11 low timer silent", 32'(lo_cnt - lb), 0);
    wr(4'h8, 32'h0);
    idle(6);
  endtask

  task automatic t_cascade;
    logic [31:0] v;
    int lb, hb, k;
    wr(4'h3, 32'h0);
    wr(4'h9, 32'hFFFF_FFFA);
    wr(4'hB, 32'h0);
    wr(4'h8, 32'h2);
    idle(6);
    wr(4'h5, 32'h1);
    rd(4'h5, v); chk(v == 1, "R2 chaining select reads back", v, 1);
    rd(4'hD, v); chk(v == 0, "R2 select absent at high address", v, 0);
    wr(4'h8, 32'h3);
    idle(10);
    rd(4'hC, v); chk(v == 1, "R10 high ctrl write pending without low overflow", v, 1);
    lb = lo_cnt; hb = hi_cnt;
    wr(4'h0, 32'h3);
    wait_lo(lb + 2);
    rd(4'hC, v); chk(v == 1, "R10 high ctrl pending after 2 low overflows", v, 1);
    wait_lo(lb + 3);
    @(negedge clk); #1;
    rd(4'hC, v); chk(v == 0, "R10 high ctrl commits on 3rd low overflow", v, 0);
    rd(4'h8, v); chk(v == 3, "R2 high ctrl reads back", v, 3);
    k = 0;
    while (hi_cnt < hb + 1 && k < 2000) begin @(negedge clk); #1; k++; end
    chk(hi_at_lo - lb == 9, "R10 first high overflow at 9th low overflow",
        32'(hi_at_lo - lb), 9);
    k = 0;
    while (hi_cnt < hb + 2 && k < 2000) begin @(negedge clk); #1; k++; end
    chk(hi_at_lo - lb == 15, "R10 R7 next high overflow 6 low overflows later",
        32'(hi_at_lo - lb), 15);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    idle(4);
    rst_n = 1'b1;
    idle(2);
    t_reset;
    tick = 1'b1;
    idle(2);
    t_posted_load;
    t_read_lag;
    t_trigger;
    t_wait;
    t_sparse;
    t_autoreload;
    t_wrap_zero;
    t_hi_solo;
    t_cascade;
    idle(4);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule